// File: doc/BRIEF.md
# Selectable Periodic Wake-Up Timer

This block produces a periodic wake-up event for a low-power system. It counts strobes from one of two time bases that share the system clock: a slow tick with a nominal 1 ms spacing, or a fast tick at a 32 kHz reference rate. A 3-bit period code picks one of seven timeout lengths or turns the timer off. When the count reaches the chosen length, a sticky flag is raised and the count starts again, so events repeat without any software involvement. Software clears the flag through an acknowledge strobe. An enable bit gates the flag onto the interrupt request line.

The period lengths do not form one power-of-two ladder. The shortest setting is a short step (8 slow ticks, or 256 fast ticks). From the second code on, each step doubles the length. The slow tick comes from a prescaler that runs freely and that this block does not reset. The first timeout after the timer is armed can therefore be up to one slow tick shorter than nominal.

Two state machines make up the block. The count machine has the states CS_OFF and CS_RUN. It follows *start* (CS_OFF to CS_RUN when a non-zero code arrives), *stop* (CS_RUN to CS_OFF when code 0 arrives), *retune* (CS_RUN to CS_RUN on a new non-zero code or a new source, which clears the count) and *wrap* (CS_RUN to CS_RUN on the terminal strobe, which reloads zero). The flag machine has the states FS_CLEAR and FS_SET. It follows *raise* (FS_CLEAR to FS_SET on a terminal strobe) and *release* (FS_SET to FS_CLEAR on an acknowledge when no terminal strobe occurs in the same cycle).

Top module: `wake_timer`

## Requirements
- R1: Period code 0 stops the timer on either source: no strobe can set the flag while the code is 0.
- R2: With the source select at 0 (slow tick), codes 1 to 7 give timeouts of 8, 32, 64, 128, 256, 512 and 1024 slow strobes.
- R3: With the source select at 1 (fast tick), codes 1 to 7 give timeouts of 256, 1024, 2048, 4096, 8192, 16384 and 32768 fast strobes.
- R4: Only the strobe of the selected source advances the count. The other strobe has no effect.
- R5: The flag is set by the strobe that completes the timeout, one clock after that strobe is sampled. The count then restarts from zero, so the next event follows after another full timeout.
- R6: A high level on the acknowledge input during a clock cycle clears the flag at the end of that cycle.
- R7: If an acknowledge and a timeout-completing strobe fall in the same cycle, the flag stays set.
- R8: A change of the period code or of the source select restarts the count from zero. A strobe in the cycle of the change is not counted.
- R9: The interrupt request is high exactly when the flag is set and the interrupt enable input is high.
- R10: After reset the flag and the interrupt request are low and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow_i | input | 1 | One-cycle strobe of the slow (1 kHz) time base |
| tick_fast_i | input | 1 | One-cycle strobe of the fast (32 kHz) time base |
| src_fast_i | input | 1 | Source select: 0 slow tick, 1 fast tick |
| period_sel_i | input | 3 | Period code; 0 stops the timer |
| ack_i | input | 1 | Flag acknowledge, clears the flag |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
Every cycle, the assertions check the local rules of the two state machines. They check that the flag rises only on a terminal strobe and that an acknowledge without a terminal strobe clears it. They also check that a stopped timer never raises the flag, that a retune leaves the count at zero, that the count never passes its terminal value, and that the request never appears without the flag. The bench scenarios show what no single-cycle property can. These are the exact timeout length for every code on both sources, the count restarting after a period change in mid-count, the repeating events after a wrap, the unselected strobe being ignored, and the outcome of an acknowledge colliding with a terminal strobe.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;

    // Count machine: stopped or counting strobes
    typedef enum logic {
        CS_OFF,
        CS_RUN
    } cnt_state_e;

    // Flag machine: sticky event flag
    typedef enum logic {
        FS_CLEAR,
        FS_SET
    } flag_state_e;

endpackage

// File: rtl/wake_tick_sel.sv
module wake_tick_sel (
    input  logic tick_slow_i,
    input  logic tick_fast_i,
    input  logic src_fast_i,
    output logic tick_o
);

    // Only the strobe of the chosen time base reaches the counter
    always_comb begin
        tick_o = src_fast_i ? tick_fast_i : tick_slow_i;
    end

endmodule

// File: rtl/wake_term_dec.sv
module wake_term_dec #(
    parameter int SEL_W          = 3,
    parameter int SLOW_MIN_LOG2  = 3,
    parameter int SLOW_STEP_BASE = 3,
    parameter int FAST_MIN_LOG2  = 8,
    parameter int FAST_STEP_BASE = 8,
    parameter int CNT_W          = 15
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             src_fast_i,
    output logic [CNT_W-1:0] term_o
);

    // Code 1 is the short first step; from code 2 upward the
    // length doubles per code, offset by a per-source base.
    int unsigned lg;

    always_comb begin
        if (sel_i == SEL_W'(1)) begin
            lg = src_fast_i ? FAST_MIN_LOG2 : SLOW_MIN_LOG2;
        end else begin
            lg = 32'(sel_i) + (src_fast_i ? FAST_STEP_BASE : SLOW_STEP_BASE);
        end
        term_o = CNT_W'((64'd1 << lg) - 64'd1);
    end

endmodule

// File: rtl/wake_counter.sv
module wake_counter
    import wake_timer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             src_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             src_q_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o,
    output logic             chg_o,
    output cnt_state_e       state_o
);

    cnt_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             src_q;
    logic [CNT_W-1:0] cnt_q;
    logic             chg;

    assign chg = (sel_i != sel_q) || (src_i != src_q);

    // Next-state logic: start, stop, retune, wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_OFF: if (chg && sel_i != '0) state_d = CS_RUN;   // start
            CS_RUN: if (chg && sel_i == '0) state_d = CS_OFF;   // stop
            default: state_d = CS_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the count machine
    always_comb begin
        hit_o = (state_q == CS_RUN) && !chg && tick_i && (cnt_q == term_i);
        chg_o   = chg;
        state_o = state_q;
        sel_q_o = sel_q;
        src_q_o = src_q;
        cnt_o   = cnt_q;
    end

    // Configuration capture and strobe count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            src_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            sel_q <= sel_i;
            src_q <= src_i;
            if (chg || state_q == CS_OFF) begin
                cnt_q <= '0;                      // retune or stopped
            end else if (hit_o) begin
                cnt_q <= '0;                      // wrap
            end else if (tick_i) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wake_flag.sv
module wake_flag
    import wake_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_i,
    input  logic        ack_i,
    input  logic        irq_en_i,
    output logic        flag_o,
    output logic        irq_o,
    output flag_state_e state_o
);

    flag_state_e state_q, state_d;

    // raise on a terminal strobe; release on ack unless an event collides
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAR: if (hit_i) state_d = FS_SET;
            FS_SET:   if (ack_i && !hit_i) state_d = FS_CLEAR;
            default:  state_d = FS_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_o  = (state_q == FS_SET);
        irq_o   = (state_q == FS_SET) && irq_en_i;
        state_o = state_q;
    end

endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int SEL_W          = 3,
    parameter int SLOW_MIN_LOG2  = 3,
    parameter int SLOW_STEP_BASE = 3,
    parameter int FAST_MIN_LOG2  = 8,
    parameter int FAST_STEP_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow_i,
    input  logic             tick_fast_i,
    input  logic             src_fast_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic             ack_i,
    input  logic             irq_en_i,
    output logic             flag_o,
    output logic             irq_o
);

    localparam int MAX_CODE = (1 << SEL_W) - 1;
    localparam int MAX_LOG2 = (FAST_STEP_BASE > SLOW_STEP_BASE ? FAST_STEP_BASE : SLOW_STEP_BASE) + MAX_CODE;
    localparam int CNT_W    = MAX_LOG2;

    logic             tick_sel;
    logic [SEL_W-1:0] sel_q;
    logic             src_q;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             sel_chg;
    cnt_state_e       cnt_state;
    flag_state_e      flag_state;

    wake_tick_sel u_tick_sel (
        .tick_slow_i (tick_slow_i),
        .tick_fast_i (tick_fast_i),
        .src_fast_i  (src_fast_i),
        .tick_o      (tick_sel)
    );

    wake_term_dec #(
        .SEL_W          (SEL_W),
        .SLOW_MIN_LOG2  (SLOW_MIN_LOG2),
        .SLOW_STEP_BASE (SLOW_STEP_BASE),
        .FAST_MIN_LOG2  (FAST_MIN_LOG2),
        .FAST_STEP_BASE (FAST_STEP_BASE),
        .CNT_W          (CNT_W)
    ) u_term_dec (
        .sel_i      (sel_q),
        .src_fast_i (src_q),
        .term_o     (term)
    );

    wake_counter #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_sel),
        .sel_i   (period_sel_i),
        .src_i   (src_fast_i),
        .term_i  (term),
        .sel_q_o (sel_q),
        .src_q_o (src_q),
        .cnt_o   (cnt_q),
        .hit_o   (hit),
        .chg_o   (sel_chg),
        .state_o (cnt_state)
    );

    wake_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .ack_i    (ack_i),
        .irq_en_i (irq_en_i),
        .flag_o   (flag_o),
        .irq_o    (irq_o),
        .state_o  (flag_state)
    );

endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk
    import wake_timer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] period_sel_i,
    input logic             ack_i,
    input logic             flag_o,
    input logic             irq_o,
    input logic             hit,
    input logic             sel_chg,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] term,
    input cnt_state_e       cnt_state
);

    // R1: a stopped timer never raises the flag
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (period_sel_i == '0 && !flag_o) |=> !flag_o);

    // R5: a terminal strobe leaves the flag set
    p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);

    // R5: the flag never rises without a terminal strobe
    p_no_stray_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !hit) |=> !flag_o);

    // R5: the count stays within the selected timeout
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CS_RUN) |-> (cnt_q <= term));

    // R6: acknowledge without a colliding event clears the flag
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !hit) |=> !flag_o);

    // R7: a colliding event beats the acknowledge
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && hit) |=> flag_o);

    // R8: a retune restarts the count from zero
    p_retune_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (cnt_q == '0));

    // R9: no request without the flag
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

endmodule

bind wake_timer wake_timer_chk #(
    .SEL_W (SEL_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_sel_i (period_sel_i),
    .ack_i        (ack_i),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .hit          (hit),
    .sel_chg      (sel_chg),
    .cnt_q        (cnt_q),
    .term         (term),
    .cnt_state    (cnt_state)
);

// File: tb/tb_wake_timer.sv
`timescale 1ns/1ps
module tb_wake_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       src_fast = 1'b0;
    logic [2:0] period_sel = 3'd0;
    logic       ack = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int seen = 0;
    logic cfg_mark = 1'b0;
    logic prev_flag = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    wake_timer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_slow_i  (tick_slow),
        .tick_fast_i  (tick_fast),
        .src_fast_i   (src_fast),
        .period_sel_i (period_sel),
        .ack_i        (ack),
        .irq_en_i     (irq_en),
        .flag_o       (flag),
        .irq_o        (irq)
    );

    // Timeout lengths taken from R2 (slow) and R3 (fast)
    function automatic int exp_len(input logic fast, input int code);
        int slow_tab[8] = '{0, 8, 32, 64, 128, 256, 512, 1024};
        int fast_tab[8] = '{0, 256, 1024, 2048, 4096, 8192, 16384, 32768};
        return fast ? fast_tab[code] : slow_tab[code];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops the expected length on each flag rise
    always @(negedge clk) begin
        if (rst_n) begin
            if (flag && !prev_flag) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected event", 1, 0);
                end else begin
                    check("R2/R3/R5 timeout length", seen, exp_q.pop_front());
                end
                seen = 0;
            end
            prev_flag = flag;
            if (cfg_mark) seen = 0;
            if (src_fast ? tick_fast : tick_slow) seen++;
        end
    end

    // Driver tasks: inputs change 1 ns after the rising edge
    task automatic cfg(input logic fast, input logic [2:0] code);
        @(posedge clk); #1;
        src_fast = fast; period_sel = code;
        tick_slow = 0; tick_fast = 0; ack = 0; cfg_mark = 1;
    endtask

    task automatic ticks(input int n, input logic s, input logic f, input logic ack_last);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cfg_mark = 0; tick_slow = s; tick_fast = f;
            ack = ack_last && (i == n - 1);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        cfg_mark = 0; tick_slow = 0; tick_fast = 0; ack = 0;
    endtask

    task automatic ack_pulse();
        @(posedge clk); #1;
        cfg_mark = 0; tick_slow = 0; tick_fast = 0; ack = 1;
        idle();
    endtask

    task automatic sample_flag(input string req, input int exp);
        @(negedge clk);
        check(req, int'(flag), exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            check("watchdog", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        irq_en = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R10 flag after reset", int'(flag), 0);
        check("R10 irq after reset", int'(irq), 0);

        // R1: code 0 on both sources
        cfg(1'b0, 3'd0); ticks(40, 1, 1, 0); idle();
        sample_flag("R1 slow source stopped", 0);
        cfg(1'b1, 3'd0); ticks(300, 1, 1, 0); idle();
        sample_flag("R1 fast source stopped", 0);

        // R2: every slow code, unselected strobe toggling as noise
        for (int c = 1; c < 8; c++) begin
            cfg(1'b0, 3'(c));
            exp_q.push_back(exp_len(1'b0, c));
            ticks(exp_len(1'b0, c), 1, 1, 0); idle();
            sample_flag("R2 flag after slow timeout", 1);
            ack_pulse();
            sample_flag("R6 flag after ack", 0);
        end

        // R3: a spread of fast codes
        for (int c = 1; c < 8; c++) begin
            if (c == 1 || c == 2 || c == 4 || c == 7) begin
                cfg(1'b1, 3'(c));
                exp_q.push_back(exp_len(1'b1, c));
                ticks(exp_len(1'b1, c), 1, 1, 0); idle();
                sample_flag("R3 flag after fast timeout", 1);
                ack_pulse();
                sample_flag("R6 flag after ack", 0);
            end
        end

        // R4: unselected strobe alone does nothing
        cfg(1'b0, 3'd1);
        ticks(20, 0, 1, 0); idle();
        sample_flag("R4 fast strobes ignored on slow source", 0);
        exp_q.push_back(8);
        ticks(8, 1, 0, 0); idle();
        sample_flag("R4 slow strobes counted", 1);
        ack_pulse();
        cfg(1'b1, 3'd1);
        ticks(300, 1, 0, 0); idle();
        sample_flag("R4 slow strobes ignored on fast source", 0);

        // R5: periodic reload without reconfiguration
        cfg(1'b0, 3'd1);
        exp_q.push_back(8); exp_q.push_back(8);
        ticks(8, 1, 0, 0); idle();
        sample_flag("R5 first period", 1);
        ack_pulse();
        ticks(7, 1, 0, 0); idle();
        sample_flag("R5 one short of second period", 0);
        ticks(1, 1, 0, 0); idle();
        sample_flag("R5 second period", 1);

        // R9: request follows flag and enable
        irq_en = 0;
        @(negedge clk);
        check("R9 irq masked", int'(irq), 0);
        irq_en = 1;
        @(negedge clk);
        check("R9 irq enabled", int'(irq), 1);

        // R7: flag still set, ack collides with terminal strobe
        cfg(1'b0, 3'd1);
        ticks(8, 1, 0, 1); idle();
        sample_flag("R7 event wins over ack", 1);
        ack_pulse();
        sample_flag("R6 ack after collision", 0);

        // R8: period change in mid-count restarts from zero
        cfg(1'b0, 3'd1);
        ticks(5, 1, 0, 0);
        cfg(1'b0, 3'd2);
        exp_q.push_back(32);
        ticks(31, 1, 0, 0); idle();
        sample_flag("R8 not yet at new period", 0);
        ticks(1, 1, 0, 0); idle();
        sample_flag("R8 new period from zero", 1);
        ack_pulse();

        // R8: source change restarts the count too
        cfg(1'b0, 3'd1);
        ticks(6, 1, 1, 0);
        cfg(1'b1, 3'd1);
        exp_q.push_back(256);
        ticks(256, 1, 1, 0); idle();
        sample_flag("R8 source change restart", 1);
        ack_pulse();

        repeat (2) @(negedge clk);
        check("R5 all expected events seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule